// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Write Port

This block receives writes from a host processor over an asynchronous parallel bus and turns each finished transfer into a one-clock byte event on the system clock. It works with either of two common bus styles. In the strobe-per-direction style, a write is marked by a dedicated active-low write strobe. In the enable style, a single enable strobe is qualified by a read/write level. A strap pin chooses the style while reset is held. The style cannot change until the next reset.

A companion line, sampled with every transfer, labels the resulting byte as display data (high) or as a command (low). After reset the port takes one full byte per strobe. A particular command byte moves the port to half-width operation, and another moves it back. In half-width operation each byte takes two strobes on the upper four data lines, the high nibble first.

All bus pins pass through a two-stage synchronizer. Strobe edges are detected in the clock domain, so each byte appears on the outputs three clocks after the latching edge.

Top module: `host_bus_port`

## Requirements
- R1: When reset (`rst_n` low, sampled on the clock) is released, `byte_valid` is low and the port is in full-byte mode, so a single transfer yields one byte.
- R2: With the strap low, a rising edge on `wr_n_rw` while `cs_n` is low yields one byte equal to `d[7:0]` as held around that edge.
- R3: With the strap low, a strobe on `wr_n_rw` while `cs_n` is high produces no byte.
- R4: With the strap high, a falling edge on `e_rd` while `cs_n` is low and `wr_n_rw` is low yields one byte equal to `d[7:0]`.
- R5: With the strap high, an `e_rd` strobe while `wr_n_rw` is high (a read cycle) produces no byte.
- R6: `is_data` equals the `a0` level captured with the transfer that completes the byte (1 = display data, 0 = command).
- R7: `mode68` is captured only while reset is asserted; changing it after release has no effect on the bus style.
- R8: A command byte (`is_data` 0) whose bits [7:5] are 3'b001 sets the width: bit 4 = 1 selects full-byte mode, and bit 4 = 0 selects nibble mode. Data bytes with the same pattern, and other commands, leave the width unchanged.
- R9: In nibble mode each byte needs two transfers on `d[7:4]`: the first gives bits [7:4] and the second gives bits [3:0]. `d[3:0]` is ignored, and only the second transfer produces a byte.
- R10: `byte_valid` is a single-clock pulse. It is high in exactly the third clock after the latching strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode68 | input | 1 | Bus style strap: 0 = write strobe style, 1 = enable plus read/write style |
| cs_n | input | 1 | Active-low chip select |
| a0 | input | 1 | Data/command tag: 1 = display data, 0 = command |
| wr_n_rw | input | 1 | Write strobe (style 0) or read/write level (style 1, 0 = write) |
| e_rd | input | 1 | Enable strobe (style 1); unused in style 0 |
| d | input | 8 | Host data bus |
| byte_valid | output | 1 | One-clock pulse per completed byte |
| byte_data | output | 8 | Completed byte |
| is_data | output | 1 | Tag of the completed byte |

## Verification
The assertions assume that the host holds every strobe level for at least two clocks. They also assume that data, tag and select stay steady for two clocks on each side of the latching edge, so that two byte events can never land on adjacent clocks. The bench holds each level for three or more clocks. It changes data and select only while the strobe is idle, and it moves the strap only during reset or during a deliberate post-release toggle. Every write then lands as one clean edge in the synchronized domain.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    localparam int BUS_W       = 8;
    localparam int NIB_W       = BUS_W / 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        BUS_STROBE = 1'b0,
        BUS_ENABLE = 1'b1
    } bus_style_e;

    typedef enum logic {
        WIDTH_NIB  = 1'b0,
        WIDTH_FULL = 1'b1
    } xfer_width_e;

    typedef struct packed {
        logic             cs_n;
        logic             tag;
        logic             wr;
        logic             en;
        logic [BUS_W-1:0] bus;
    } pin_sample_t;

    typedef struct packed {
        logic             tag_data;
        logic [BUS_W-1:0] val;
    } host_word_t;

    localparam pin_sample_t PIN_IDLE = '{cs_n: 1'b1, tag: 1'b0, wr: 1'b1,
                                          en: 1'b0, bus: '0};

    function automatic logic is_width_cmd(host_word_t w);
        return (!w.tag_data) && (w.val[BUS_W-1 -: 3] == 3'b001);
    endfunction

    function automatic xfer_width_e width_of_cmd(host_word_t w);
        return w.val[NIB_W] ? WIDTH_FULL : WIDTH_NIB;
    endfunction
endpackage

// File: rtl/hbp_mode_strap.sv
module hbp_mode_strap
    import hbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strap,
    output bus_style_e style
);
    bus_style_e style_q;

    always_ff @(posedge clk) begin
        if (rst) style_q <= strap ? BUS_ENABLE : BUS_STROBE;
    end

    assign style = style_q;

    assert_strap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(style_q));
endmodule

// File: rtl/hbp_pin_sync.sv
module hbp_pin_sync
    import hbp_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic        clk,
    input  logic        rst,
    input  pin_sample_t raw,
    output pin_sample_t synced
);
    pin_sample_t stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= PIN_IDLE;
                    else     stage_q[g] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= PIN_IDLE;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/hbp_edge_detect.sv
module hbp_edge_detect
    import hbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_style_e  style,
    input  pin_sample_t cur,
    output logic        evt,
    output host_word_t  word
);
    pin_sample_t prev_q;
    logic        strobe_hit;
    logic        qualified;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PIN_IDLE;
        else     prev_q <= cur;
    end

    always_comb begin
        unique case (style)
            BUS_STROBE: begin
                strobe_hit = !prev_q.wr && cur.wr;
                qualified  = !prev_q.cs_n;
            end
            BUS_ENABLE: begin
                strobe_hit = prev_q.en && !cur.en;
                qualified  = !prev_q.cs_n && !prev_q.wr;
            end
            default: begin
                strobe_hit = 1'b0;
                qualified  = 1'b0;
            end
        endcase
    end

    assign evt           = strobe_hit && qualified;
    assign word.tag_data = prev_q.tag;
    assign word.val      = prev_q.bus;

    assert_evt_spacing_R10: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);
endmodule

// File: rtl/hbp_nibble_asm.sv
module hbp_nibble_asm
    import hbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  host_word_t word,
    output logic       out_valid,
    output host_word_t out_word
);
    xfer_width_e      width_q;
    logic             phase_q;
    logic [NIB_W-1:0] upper_q;
    logic             out_valid_q;
    host_word_t       out_q;

    host_word_t       asm_word;
    logic             done;

    always_comb begin
        if (width_q == WIDTH_FULL) begin
            asm_word = word;
        end else begin
            asm_word.tag_data = word.tag_data;
            asm_word.val      = {upper_q, word.val[BUS_W-1 -: NIB_W]};
        end
        done = evt && ((width_q == WIDTH_FULL) || phase_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q     <= WIDTH_FULL;
            phase_q     <= 1'b0;
            upper_q     <= '0;
            out_valid_q <= 1'b0;
            out_q       <= '0;
        end else begin
            out_valid_q <= done;
            if (done) out_q <= asm_word;
            if (evt && width_q == WIDTH_NIB && !phase_q) begin
                upper_q <= word.val[BUS_W-1 -: NIB_W];
                phase_q <= 1'b1;
            end else if (done) begin
                phase_q <= 1'b0;
            end
            if (done && is_width_cmd(asm_word)) begin
                width_q <= width_of_cmd(asm_word);
                if (width_of_cmd(asm_word) != width_q) phase_q <= 1'b0;
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_word  = out_q;

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid_q |=> !out_valid_q);

    assert_full_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (evt && width_q == WIDTH_FULL) |=> out_valid_q);

    assert_phase_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (width_q == WIDTH_FULL) |-> !phase_q);

    assert_width_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid_q && is_width_cmd(out_q)) |-> (width_q == width_of_cmd(out_q)));
endmodule

// File: rtl/host_bus_port.sv
module host_bus_port
    import hbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode68,
    input  logic             cs_n,
    input  logic             a0,
    input  logic             wr_n_rw,
    input  logic             e_rd,
    input  logic [BUS_W-1:0] d,
    output logic             byte_valid,
    output logic [BUS_W-1:0] byte_data,
    output logic             is_data
);
    logic        rst;
    bus_style_e  style;
    pin_sample_t raw;
    pin_sample_t synced;
    logic        evt;
    host_word_t  word;
    host_word_t  out_word;

    assign rst = !rst_n;

    assign raw.cs_n = cs_n;
    assign raw.tag  = a0;
    assign raw.wr   = wr_n_rw;
    assign raw.en   = e_rd;
    assign raw.bus  = d;

    hbp_mode_strap u_strap (
        .clk   (clk),
        .rst   (rst),
        .strap (mode68),
        .style (style)
    );

    hbp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw),
        .synced (synced)
    );

    hbp_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .style (style),
        .cur   (synced),
        .evt   (evt),
        .word  (word)
    );

    hbp_nibble_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .word      (word),
        .out_valid (byte_valid),
        .out_word  (out_word)
    );

    assign byte_data = out_word.val;
    assign is_data   = out_word.tag_data;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !byte_valid);
endmodule

// File: tb/host_bus_port_tb.sv
module host_bus_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode68 = 1'b0;
    logic       cs_n = 1'b1;
    logic       a0 = 1'b0;
    logic       wr_n_rw = 1'b1;
    logic       e_rd = 1'b0;
    logic [7:0] d = 8'h00;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       is_data;

    int  checks = 0;
    int  failures = 0;
    bit  m68 = 1'b0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    host_bus_port u_dut (
        .clk(clk), .rst_n(rst_n), .mode68(mode68), .cs_n(cs_n), .a0(a0),
        .wr_n_rw(wr_n_rw), .e_rd(e_rd), .d(d),
        .byte_valid(byte_valid), .byte_data(byte_data), .is_data(is_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap, input logic after);
        @(negedge clk);
        rst_n = 1'b0; mode68 = strap; cs_n = 1'b1; a0 = 1'b0;
        wr_n_rw = 1'b1; e_rd = strap ? 1'b0 : 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mode68 = after;
        m68 = strap;
        chk(byte_valid == 1'b0, "R1", byte_valid, 0);
        repeat (2) @(negedge clk);
    endtask

    // One bus write; checks pulse timing (third clock) and payload.
    task automatic xfer(input logic [7:0] v, input logic a0v, input logic csn,
                        input logic rwv, input bit exp_pulse,
                        input logic [7:0] eb, input logic ed, input string req);
        int pulses = 0;
        @(negedge clk);
        cs_n = csn; a0 = a0v; d = v;
        if (m68) begin wr_n_rw = rwv; e_rd = 1'b1; end
        else     begin wr_n_rw = 1'b0; end
        repeat (3) @(negedge clk);
        if (m68) e_rd = 1'b0; else wr_n_rw = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 3) begin
                chk(byte_valid == exp_pulse, {req, "/R10 pulse@3"}, byte_valid, exp_pulse);
                if (exp_pulse && byte_valid) begin
                    chk(byte_data == eb, {req, " data"}, byte_data, eb);
                    chk(is_data == ed, {req, "/R6 tag"}, is_data, ed);
                end
            end
            if (byte_valid) pulses++;
        end
        chk(pulses == int'(exp_pulse), "R10 pulse count", pulses, int'(exp_pulse));
        @(negedge clk);
        cs_n = 1'b1; a0 = 1'b0;
        if (m68) wr_n_rw = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic full_byte(input logic [7:0] v, input logic a0v, input string req);
        xfer(v, a0v, 1'b0, 1'b0, 1'b1, v, a0v, req);
    endtask

    // Nibble pair: high nibble first on d[7:4], junk on d[3:0]
    task automatic nib_byte(input logic [7:0] v, input logic a0_first,
                            input logic a0_second, input string req);
        xfer({v[7:4], ~v[3:0]}, a0_first, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, {req, " first"});
        xfer({v[3:0], v[7:4]}, a0_second, 1'b0, 1'b0, 1'b1, v, a0_second, {req, " second"});
    endtask

    initial begin
        // Strobe style, strap toggled after release (R7)
        do_reset(1'b0, 1'b1);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v = 8'(i * 17) ^ 8'h5A;
            if (v[7:5] == 3'b001) v = v ^ 8'h80;
            full_byte(v, 1'(i), "R2/R7");
        end
        xfer(8'hC3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R3");
        xfer(8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R3");
        // Data byte with width pattern and unrelated command: width stays full (R8)
        full_byte(8'h20, 1'b1, "R8 data 0x20");
        full_byte(8'h40, 1'b0, "R8 cmd 0x40");
        full_byte(8'h7E, 1'b1, "R8 still full");
        // Switch to nibble mode and sweep
        full_byte(8'h27, 1'b0, "R8 to nibble");
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v = {4'(i), 4'(15 - i) ^ 4'h3};
            if (v[7:5] == 3'b001) v[7] = 1'b1;
            nib_byte(v, ~1'(i), 1'(i), "R9/R6");
        end
        nib_byte(8'h20, 1'b1, 1'b1, "R8 nibble data 0x20");
        nib_byte(8'h9A, 1'b1, 1'b0, "R9 still nibble");
        nib_byte(8'h3F, 1'b0, 1'b0, "R8 to full");
        full_byte(8'hA5, 1'b1, "R8 full again");

        // Enable style, strap toggled after release (R7)
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v = 8'(i * 29) + 8'h81;
            if (v[7:5] == 3'b001) v = v ^ 8'h80;
            full_byte(v, 1'(i >> 1), "R4/R7/R1");
        end
        xfer(8'h66, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R5");
        xfer(8'h99, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R4 cs high");
        full_byte(8'h21, 1'b0, "R8 to nibble");
        nib_byte(8'hE4, 1'b0, 1'b1, "R9 enable style");
        xfer(8'h50, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R5 nibble read");
        nib_byte(8'h1B, 1'b1, 1'b0, "R9 read ignored");

        // Reset restores full-byte mode (R1)
        do_reset(1'b0, 1'b0);
        full_byte(8'hD2, 1'b0, "R1 full after reset");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule